// File: doc/BRIEF.md
# Frame-Pulse TDM Voice Timeslot Port

This block connects a voice datapath to a serial time-division bus. The bus frame is 32 timeslots of 8 bits. An active-low frame pulse marks the start of each frame, and the port runs from a clock at twice the bit rate. A 2-bit mode picks which timeslots carry the voice sample. The sample is either one 8-bit companded byte or one 16-bit two's-complement linear word that spans two slots. One mode also routes the first two slots from the serial input to the serial output unchanged.

On receive, the port collects the selected bits into a parallel word. It raises a one-cycle valid strobe once per frame, after the last selected bit. On transmit, it captures a parallel word at the frame pulse and shifts it out MSB first in the selected slots. The output enable is low in every other slot, so the pad can float there. The port counts as locked only while frame pulses keep arriving exactly one frame apart.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is asserted, and after it until the first frame pulse, `dx_oe_o`, `rx_valid_o` and `frame_lock_o` are 0.
- R2: A frame pulse is a high-to-low transition of `fp_ni` seen at a clock edge. The cycle after that edge is the first half of bit 0 (the MSB) of slot 0. Each bit lasts 2 clocks, each slot 8 bits, and each frame 32 slots (512 clocks).
- R3: Mode 00 sends `tx_data_i[7:0]` MSB first in slot 0 and receives slot 0 into `rx_data_o[7:0]`, with `rx_data_o[15:8]`=0.
- R4: Mode 01 sends and receives the 8-bit sample in slot 2.
- R5: Mode 10 carries the 8-bit sample in slot 2. In slots 0 and 1 it drives `dx_o` equal to `dr_i`, with `dx_oe_o`=1.
- R6: Mode 11 carries a 16-bit word. Bits 15:8 go in slot 0 and bits 7:0 in slot 1, each byte MSB first.
- R7: `dx_oe_o` is 1 only in the data or bypass slots of the current mode while locked. `dx_o` is 0 whenever `dx_oe_o` is 0.
- R8: `mode_i` and `tx_data_i` are sampled only at the frame-pulse edge. Changing them mid-frame does not change the output of that frame.
- R9: A frame pulse sets `frame_lock_o`. If the last cycle of a frame passes without a pulse, the lock clears. A pulse at any other point realigns the counters to slot 0.
- R10: While locked, `rx_valid_o` is high for exactly one cycle per frame. That cycle is the one that follows the last clock of the last selected slot.
- R11: Each received bit is sampled at the clock edge that ends its second half. The first half of the bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_ni | input | 1 | Frame pulse, active low |
| mode_i | input | 2 | Timeslot mode select |
| tx_data_i | input | 16 | Transmit sample, captured at the frame pulse |
| dr_i | input | 1 | Serial receive data |
| dx_o | output | 1 | Serial transmit data |
| dx_oe_o | output | 1 | Transmit output enable for the pad |
| rx_data_o | output | 16 | Received sample |
| rx_valid_o | output | 1 | One-cycle strobe for a new `rx_data_o` |
| frame_lock_o | output | 1 | Frame pulses arrive at the expected interval |

## Verification
The assertions assume that `fp_ni` stays low for at most one clock. They also assume that `mode_i` matters only at the pulse edge, so the bypass and enable checks follow the registered mode and not the input pin. The stimulus always drives exactly one low cycle of `fp_ni`, either in the last clock of a frame or, for the realignment case, at an arbitrary cycle. Mid-frame, it inverts `mode_i` and `tx_data_i` on purpose to show that they are sampled only at the pulse. Each received bit is driven inverted in its first half, so a design that samples early returns the wrong word.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;

  typedef enum logic [1:0] {
    MODE_TS0     = 2'b00,
    MODE_TS2     = 2'b01,
    MODE_TS2_BYP = 2'b10,
    MODE_LIN16   = 2'b11
  } pcm_mode_e;

  typedef struct packed {
    logic data;     // slot carries sample bits
    logic bypass;   // slot is routed dr -> dx
    logic hi_byte;  // slot holds the upper byte of a 16-bit word
    logic last;     // final data slot of the frame
  } slot_attr_t;

endpackage

// File: rtl/pcm_tdm_timer.sv
module pcm_tdm_timer #(
  parameter int NUM_TS    = 32,
  parameter int TS_W      = 8,
  parameter int TS_IDX_W  = $clog2(NUM_TS),
  parameter int BIT_IDX_W = $clog2(TS_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fp_ni,
  output logic                 fp_start_o,
  output logic [TS_IDX_W-1:0]  ts_idx_o,
  output logic [BIT_IDX_W-1:0] bit_idx_o,
  output logic                 half_o,
  output logic                 lock_o
);

  localparam logic [TS_IDX_W-1:0]  TS_LAST  = TS_IDX_W'(NUM_TS - 1);
  localparam logic [BIT_IDX_W-1:0] BIT_LAST = BIT_IDX_W'(TS_W - 1);

  logic fp_q;
  logic frame_term;

  assign fp_start_o = fp_q & ~fp_ni;
  assign frame_term = (ts_idx_o == TS_LAST) && (bit_idx_o == BIT_LAST) && half_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fp_q <= 1'b1;
    else         fp_q <= fp_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_idx_o  <= '0;
      bit_idx_o <= '0;
      half_o    <= 1'b0;
      lock_o    <= 1'b0;
    end else if (fp_start_o) begin
      ts_idx_o  <= '0;
      bit_idx_o <= '0;
      half_o    <= 1'b0;
      lock_o    <= 1'b1;
    end else begin
      half_o <= ~half_o;
      if (half_o) begin
        if (bit_idx_o == BIT_LAST) begin
          bit_idx_o <= '0;
          ts_idx_o  <= (ts_idx_o == TS_LAST) ? '0 : ts_idx_o + 1'b1;
        end else begin
          bit_idx_o <= bit_idx_o + 1'b1;
        end
      end
      // expected pulse missing at frame end
      if (frame_term) lock_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pcm_slot_map.sv
module pcm_slot_map
  import pcm_tdm_pkg::*;
#(
  parameter int TS_IDX_W = 5
) (
  input  pcm_mode_e            mode_i,
  input  logic [TS_IDX_W-1:0]  ts_idx_i,
  output slot_attr_t           attr_o
);

  localparam logic [TS_IDX_W-1:0] TS_0 = TS_IDX_W'(0);
  localparam logic [TS_IDX_W-1:0] TS_1 = TS_IDX_W'(1);
  localparam logic [TS_IDX_W-1:0] TS_2 = TS_IDX_W'(2);

  always_comb begin
    attr_o = '0;
    unique case (mode_i)
      MODE_TS0: begin
        attr_o.data = (ts_idx_i == TS_0);
        attr_o.last = (ts_idx_i == TS_0);
      end
      MODE_TS2: begin
        attr_o.data = (ts_idx_i == TS_2);
        attr_o.last = (ts_idx_i == TS_2);
      end
      MODE_TS2_BYP: begin
        attr_o.data   = (ts_idx_i == TS_2);
        attr_o.last   = (ts_idx_i == TS_2);
        attr_o.bypass = (ts_idx_i == TS_0) || (ts_idx_i == TS_1);
      end
      MODE_LIN16: begin
        attr_o.data    = (ts_idx_i == TS_0) || (ts_idx_i == TS_1);
        attr_o.hi_byte = (ts_idx_i == TS_0);
        attr_o.last    = (ts_idx_i == TS_1);
      end
      default: attr_o = '0;
    endcase
  end

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int TS_W     = 8,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_en_i,
  input  logic                word_end_i,
  input  logic                wide_i,
  input  logic                dr_i,
  output logic [SAMPLE_W-1:0] rx_data_o,
  output logic                rx_valid_o
);

  logic [SAMPLE_W-2:0] shift_q;
  logic [SAMPLE_W-1:0] shift_nx;

  assign shift_nx = {shift_q, dr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q    <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (sample_en_i) begin
        shift_q <= shift_nx[SAMPLE_W-2:0];
        if (word_end_i) begin
          rx_data_o  <= wide_i ? shift_nx
                               : {{(SAMPLE_W-TS_W){1'b0}}, shift_nx[TS_W-1:0]};
          rx_valid_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
  parameter int TS_W      = 8,
  parameter int SAMPLE_W  = 16,
  parameter int BIT_IDX_W = $clog2(TS_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [SAMPLE_W-1:0]  tx_data_i,
  input  logic                 hi_byte_i,
  input  logic [BIT_IDX_W-1:0] bit_idx_i,
  output logic                 tx_bit_o
);

  logic [SAMPLE_W-1:0]  hold_q;
  logic [BIT_IDX_W:0]   sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= tx_data_i;
  end

  // TS_W is a power of two: ~bit_idx is TS_W-1-bit_idx (MSB first)
  assign sel      = {hi_byte_i, ~bit_idx_i};
  assign tx_bit_o = hold_q[sel];

endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int NUM_TS = 32,
  parameter int TS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_ni,
  input  logic [1:0]        mode_i,
  input  logic [2*TS_W-1:0] tx_data_i,
  input  logic              dr_i,
  output logic              dx_o,
  output logic              dx_oe_o,
  output logic [2*TS_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              frame_lock_o
);

  localparam int SAMPLE_W  = 2 * TS_W;
  localparam int TS_IDX_W  = $clog2(NUM_TS);
  localparam int BIT_IDX_W = $clog2(TS_W);
  localparam logic [BIT_IDX_W-1:0] BIT_LAST = BIT_IDX_W'(TS_W - 1);

  logic                 fp_start;
  logic [TS_IDX_W-1:0]  ts_idx;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic                 half;
  pcm_mode_e            mode_q;
  slot_attr_t           attr;
  logic                 tx_bit;

  pcm_tdm_timer #(
    .NUM_TS(NUM_TS), .TS_W(TS_W), .TS_IDX_W(TS_IDX_W), .BIT_IDX_W(BIT_IDX_W)
  ) u_timer (
    .clk_i, .rst_ni, .fp_ni,
    .fp_start_o(fp_start),
    .ts_idx_o  (ts_idx),
    .bit_idx_o (bit_idx),
    .half_o    (half),
    .lock_o    (frame_lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= MODE_TS0;
    else if (fp_start) mode_q <= pcm_mode_e'(mode_i);
  end

  pcm_slot_map #(.TS_IDX_W(TS_IDX_W)) u_map (
    .mode_i  (mode_q),
    .ts_idx_i(ts_idx),
    .attr_o  (attr)
  );

  pcm_rx_deser #(.TS_W(TS_W), .SAMPLE_W(SAMPLE_W)) u_rx (
    .clk_i, .rst_ni,
    .sample_en_i(frame_lock_o && attr.data && half),
    .word_end_i (attr.last && (bit_idx == BIT_LAST)),
    .wide_i     (mode_q == MODE_LIN16),
    .dr_i,
    .rx_data_o,
    .rx_valid_o
  );

  pcm_tx_ser #(.TS_W(TS_W), .SAMPLE_W(SAMPLE_W), .BIT_IDX_W(BIT_IDX_W)) u_tx (
    .clk_i, .rst_ni,
    .load_i   (fp_start),
    .tx_data_i,
    .hi_byte_i(attr.hi_byte),
    .bit_idx_i(bit_idx),
    .tx_bit_o (tx_bit)
  );

  assign dx_oe_o = frame_lock_o && (attr.data || attr.bypass);
  assign dx_o    = !dx_oe_o ? 1'b0 : (attr.bypass ? dr_i : tx_bit);

endmodule

// File: rtl/pcm_tdm_port_chk.sv
module pcm_tdm_port_chk
  import pcm_tdm_pkg::*;
#(
  parameter int TS_IDX_W = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fp_ni,
  input logic                dr_i,
  input logic                dx_o,
  input logic                dx_oe_o,
  input logic                rx_valid_o,
  input logic                frame_lock_o,
  input logic                fp_start,
  input pcm_mode_e           mode_q,
  input logic [TS_IDX_W-1:0] ts_idx
);

  // R7
  oe_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dx_oe_o |-> frame_lock_o);

  // R10
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R10
  valid_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> frame_lock_o);

  // R9
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_lock_o) |-> $past(!fp_ni));

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_start |=> $stable(mode_q));

  // R5
  bypass_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_lock_o && mode_q == MODE_TS2_BYP && ts_idx < TS_IDX_W'(2))
      |-> (dx_oe_o && dx_o == dr_i));

endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(.TS_IDX_W(TS_IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fp_ni       (fp_ni),
  .dr_i        (dr_i),
  .dx_o        (dx_o),
  .dx_oe_o     (dx_oe_o),
  .rx_valid_o  (rx_valid_o),
  .frame_lock_o(frame_lock_o),
  .fp_start    (fp_start),
  .mode_q      (mode_q),
  .ts_idx      (ts_idx)
);

// File: tb/pcm_tdm_port_bench.sv
module pcm_tdm_port_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fp_ni = 1'b1;
  logic [1:0]  mode_i = 2'b00;
  logic [15:0] tx_data_i = '0;
  logic        dr_i = 1'b0;
  logic        dx_o, dx_oe_o, rx_valid_o, frame_lock_o;
  logic [15:0] rx_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  pcm_tdm_port u_pcm_tdm_port (
    .clk_i, .rst_ni, .fp_ni, .mode_i, .tx_data_i, .dr_i,
    .dx_o, .dx_oe_o, .rx_data_o, .rx_valid_o, .frame_lock_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && rx_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected rx_valid", 1, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rx_data_o === e, {t, " R11"}, "rx_data", int'(rx_data_o), int'(e));
      end
    end
  end

  task automatic start_pulse(input logic [1:0] m, input logic [15:0] tx);
    mode_i = m; tx_data_i = tx; fp_ni = 1'b0;
    @(negedge clk_i);
    fp_ni = 1'b1;
  endtask

  task automatic run_frame(input logic [1:0] m, input logic [15:0] tx,
                           input logic [15:0] rxw, input logic [1:0] nm,
                           input logic [15:0] ntx, input bit pulse, input bit lk);
    int dx_err = 0, v_err = 0, act_dx = 0, exp_dx_f = 0, act_v = 0, bad_c = 0;
    int last_ts, vc;
    string tag;
    tag = (m == 2'd0) ? "R3" : (m == 2'd1) ? "R4" : (m == 2'd2) ? "R5" : "R6";
    last_ts = (m == 2'd0) ? 0 : (m == 2'd3) ? 1 : 2;
    vc = (last_ts + 1) * 16;
    if (lk) begin
      exp_q.push_back((m == 2'd3) ? rxw : {8'h00, rxw[7:0]});
      tag_q.push_back(tag);
    end
    for (int c = 0; c < 512; c++) begin
      int ts, b;
      bit data, byp, rb, e_oe, e_dx;
      ts = c / 16; b = (c % 16) / 2;
      data = (m == 2'd0) ? (ts == 0) : (m == 2'd3) ? (ts < 2) : (ts == 2);
      byp = (m == 2'd2) && (ts < 2);
      if (data) rb = (m == 2'd3 && ts == 0) ? rxw[15-b] : rxw[7-b];
      else      rb = 1'($urandom % 2);
      dr_i = (c % 2 == 0) ? ~rb : rb;  // R11: first half is decoy
      if (c == 100) begin  // R8: scramble mid-frame
        mode_i = ~m; tx_data_i = ~tx;
      end
      if (c == 511) begin
        mode_i = nm; tx_data_i = ntx; fp_ni = ~pulse;
      end
      #1;
      if (c == 0)
        chk(frame_lock_o === lk, "R9", "frame_lock", int'(frame_lock_o), int'(lk));
      e_oe = lk && (data || byp);
      e_dx = !e_oe ? 1'b0 : byp ? dr_i : ((m == 2'd3 && ts == 0) ? tx[15-b] : tx[7-b]);
      if ((dx_oe_o !== e_oe || dx_o !== e_dx) && dx_err++ == 0) begin
        act_dx = {dx_oe_o, dx_o}; exp_dx_f = {e_oe, e_dx}; bad_c = c;
      end
      if (rx_valid_o !== (lk && c == vc) && v_err++ == 0) act_v = c;
      @(negedge clk_i);
      fp_ni = 1'b1;
    end
    chk(dx_err == 0, {tag, " R7 R8 R2"}, $sformatf("dx/oe at cycle %0d", bad_c),
        act_dx, exp_dx_f);
    chk(v_err == 0, "R10 R2", $sformatf("rx_valid at cycle %0d", act_v),
        v_err, 0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1
    chk({dx_oe_o, rx_valid_o, frame_lock_o} === 3'b000, "R1", "in reset",
        int'({dx_oe_o, rx_valid_o, frame_lock_o}), 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk({dx_oe_o, rx_valid_o, frame_lock_o} === 3'b000, "R1", "before pulse",
        int'({dx_oe_o, rx_valid_o, frame_lock_o}), 0);

    start_pulse(2'd0, 16'hFFA5);
    run_frame(2'd0, 16'hFFA5, 16'h003C, 2'd1, 16'h775A, 1'b1, 1'b1);
    run_frame(2'd1, 16'h775A, 16'h00C3, 2'd2, 16'h0096, 1'b1, 1'b1);
    run_frame(2'd2, 16'h0096, 16'h0069, 2'd3, 16'hBEEF, 1'b1, 1'b1);
    run_frame(2'd3, 16'hBEEF, 16'h1234, 2'd3, 16'h8001, 1'b1, 1'b1);
    // missing pulse at end of this frame -> lock lost (R9)
    run_frame(2'd3, 16'h8001, 16'hFEDC, 2'd0, 16'h00FF, 1'b0, 1'b1);
    run_frame(2'd0, 16'h00FF, 16'h0000, 2'd0, 16'h0000, 1'b0, 1'b0);
    // realign at an arbitrary point (R9)
    repeat (37) @(negedge clk_i);
    start_pulse(2'd2, 16'h0011);
    run_frame(2'd2, 16'h0011, 16'h00E7, 2'd0, 16'h0080, 1'b1, 1'b1);
    run_frame(2'd0, 16'h0080, 16'h0001, 2'd0, 16'h0000, 1'b0, 1'b1);
    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R10", "pending rx words", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule